// File: doc/BRIEF.md
# Receive Queue Status with Programmable Thresholds

This block is the receive half of a buffered serial port. A shift engine hands it one byte at a time through a strobe. The block keeps the bytes in a sixteen-entry first-in first-out queue until a host pulls them out through a small register window. It also tells the shift engine, through a ready line, whether more bytes are welcome. The host sets two thresholds. One decides when the queue counts as "full enough" to be serviced. The other is the flow-control limit at which the ready line drops.

The queue occupancy is tracked by a three-state fill machine. Its states are `Q_EMPTY` (no bytes), `Q_SOME` (between one and fifteen bytes) and `Q_FULL` (sixteen bytes). It has four named transitions:

- **first_in**: `Q_EMPTY` to `Q_SOME`, on an accepted byte.
- **top_off**: `Q_SOME` to `Q_FULL`, on a push without a pop at fifteen bytes.
- **drain_last**: `Q_SOME` to `Q_EMPTY`, on a pop without a push at one byte.
- **make_room**: `Q_FULL` to `Q_SOME`, on a pop without a push.

Any other combination keeps the current state. A byte that arrives while the queue is full, with no pop in the same cycle, is dropped. The drop is recorded in a line status register that clears when it is read.

The register window uses a 2-bit address and 16-bit data. Its registers are:

| Address | Register | Access |
|---|---|---|
| 0 | Receive data | A read pops one byte |
| 1 | Threshold control | Read and write |
| 2 | Queue status | Read only |
| 3 | Line status | A read clears it; a write loads it |

Top module: `rxq_status`

## Requirements
- R1: After reset, the queue status register (address 2) reads 0x0060, the threshold control register (address 1) and the line status register (address 3) read 0, and `rx_ready` is high.
- R2: Bytes accepted on `rx_valid`/`rx_byte` are returned, in arrival order, in bits [7:0] of reads at address 0, with bits [15:8] zero. The queue holds up to 16 bytes.
- R3: Control bits [8:7] choose the service trigger: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14. While the fill count is at or above the trigger, queue status bit 1 is 1 and bit 0 is 0.
- R4: While the fill count is below the trigger, queue status bit 1 is 0, and bit 0 is 1 exactly when the queue is not empty. Status bits 15:2 always read 0x0060 >> 2.
- R5: Control bits [11:9] choose the acceptance limit: 0 gives 15, 1 gives 1, 2 gives 4, 3 gives 6, 4 gives 8, 5 gives 10, 6 gives 12 and 7 gives 14. `rx_ready` is high only while the fill count is below the chosen limit.
- R6: A byte strobed while 16 bytes are held, with no pop in that cycle, is discarded, and line status bit 0 (overrun) becomes 1. The stored bytes are not changed.
- R7: A read at address 3 returns the register and clears all of its bits on that clock edge. An overrun in the same cycle leaves bit 0 set afterwards.
- R8: A read at address 0 removes the returned byte, and the status flags reflect the new count from the next cycle. A read at address 0 of an empty queue returns 0 and changes nothing.
- R9: A push and a pop in the same cycle leave the count unchanged, and the pushed byte is kept even when the queue was full.
- R10: Writes to address 3 load the line status register. Writes to addresses 0 and 2 have no effect. Writes to address 1 are read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register (combinational) |
| rx_valid | input | 1 | Byte strobe from the shift engine |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | More bytes may be sent |

## Verification
The hardest situations to reach are at the top of the queue:

- an overrun landing in the same cycle as a line status read;
- a push and a pop meeting while the queue holds sixteen bytes.

Uniform random traffic hovers near an empty queue. The stimulus therefore alternates long fill-biased and drain-biased phases, so the count repeatedly climbs to sixteen and falls back to zero while the thresholds are reprogrammed at random. Directed sequences then pin the coincident overrun-with-read and full push-with-pop cases.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_SOME  = 2'd1,
        Q_FULL  = 2'd2
    } fill_e;

    localparam logic [1:0]  ADR_DATA  = 2'd0;
    localparam logic [1:0]  ADR_CTL   = 2'd1;
    localparam logic [1:0]  ADR_STAT  = 2'd2;
    localparam logic [1:0]  ADR_LINE  = 2'd3;
    localparam logic [15:0] STAT_BASE = 16'h0060;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output fill_e         state,
    output logic          dropped
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_pop, do_push;
    fill_e         state_nx;

    assign do_pop  = pop && (state != Q_EMPTY);
    assign do_push = push && ((state != Q_FULL) || do_pop);
    assign dropped = push && !do_push;
    assign dout    = mem[rd_ptr];

    // Next-state process
    always_comb begin
        state_nx = state;
        unique case (state)
            Q_EMPTY: if (do_push) state_nx = Q_SOME;
            Q_SOME: begin
                if (do_push && !do_pop && count == CW'(DEPTH - 1))
                    state_nx = Q_FULL;
                else if (do_pop && !do_push && count == CW'(1))
                    state_nx = Q_EMPTY;
            end
            Q_FULL:  if (do_pop && !do_push) state_nx = Q_SOME;
            default: state_nx = Q_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= Q_EMPTY;
        else        state <= state_nx;
    end

    // Datapath outputs: pointers and count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // R2
    push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && count < CW'(DEPTH)) |=> (count == $past(count) + 1'b1));
    // R9
    both_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && count != '0) |=> $stable(count));
    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && count == '0) |=> (count == '0));
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
    parameter int CW = 5
) (
    input  logic [CW-1:0] count,
    input  logic [1:0]    trig_sel,
    input  logic [2:0]    lim_sel,
    output logic          svc_full,
    output logic          has_data,
    output logic          accept
);
    logic [CW-1:0] trig, lim;

    always_comb begin
        unique case (trig_sel)
            2'd0: trig = CW'(1);
            2'd1: trig = CW'(4);
            2'd2: trig = CW'(8);
            default: trig = CW'(14);
        endcase
        unique case (lim_sel)
            3'd0: lim = CW'(15);
            3'd1: lim = CW'(1);
            3'd2: lim = CW'(4);
            3'd3: lim = CW'(6);
            3'd4: lim = CW'(8);
            3'd5: lim = CW'(10);
            3'd6: lim = CW'(12);
            default: lim = CW'(14);
        endcase
    end

    assign svc_full = (count >= trig);
    assign has_data = !svc_full && (count != '0);
    assign accept   = (count < lim);
endmodule

// File: rtl/rxq_status.sv
module rxq_status
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    parameter int BW    = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_cs,
    input  logic          bus_we,
    input  logic [1:0]    bus_addr,
    input  logic [BW-1:0] bus_wdata,
    output logic [BW-1:0] bus_rdata,
    input  logic          rx_valid,
    input  logic [W-1:0]  rx_byte,
    output logic          rx_ready
);
    logic [BW-1:0] ctl_q, line_q;
    logic [W-1:0]  head;
    logic [CW-1:0] count;
    fill_e         state;
    logic          dropped, svc_full, has_data;
    logic          rd_en, wr_en, pop_req;

    assign rd_en   = bus_cs && !bus_we;
    assign wr_en   = bus_cs && bus_we;
    assign pop_req = rd_en && (bus_addr == ADR_DATA);

    rxq_store #(.DEPTH(DEPTH), .W(W)) u_store (
        .clk(clk), .rst_n(rst_n), .push(rx_valid), .pop(pop_req),
        .din(rx_byte), .dout(head), .count(count), .state(state),
        .dropped(dropped)
    );

    rxq_flags #(.CW(CW)) u_flags (
        .count(count), .trig_sel(ctl_q[8:7]), .lim_sel(ctl_q[11:9]),
        .svc_full(svc_full), .has_data(has_data), .accept(rx_ready)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            line_q <= '0;
        end else begin
            if (wr_en && bus_addr == ADR_CTL) ctl_q <= bus_wdata;
            if (wr_en && bus_addr == ADR_LINE)
                line_q <= bus_wdata | BW'(dropped);
            else if (rd_en && bus_addr == ADR_LINE)
                line_q <= BW'(dropped);
            else if (dropped)
                line_q[0] <= 1'b1;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADR_DATA: bus_rdata = (state == Q_EMPTY) ? '0 : BW'(head);
            ADR_CTL:  bus_rdata = ctl_q;
            ADR_STAT: bus_rdata = STAT_BASE | BW'({svc_full, has_data});
            default:  bus_rdata = line_q;
        endcase
    end

    // R6
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !pop_req && count == CW'(DEPTH)) |=> line_q[0]);
    // R7
    line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_addr == ADR_LINE && !dropped) |=> (line_q == '0));
    // R5
    accept_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count >= CW'(15)) |-> !rx_ready);
    // R3
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> (bus_addr != ADR_STAT || bus_rdata[0] == 1'b0));
endmodule

// File: tb/rxq_status_test.sv
module rxq_status_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs = 1'b0, bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h0;
    logic        rx_ready;

    int checks = 0, errors = 0;
    logic [7:0]  q[$];
    logic [15:0] m_ctl = 16'h0, m_line = 16'h0;

    always #5 clk = ~clk;

    rxq_status uut (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready)
    );

    function automatic int trig_of(logic [15:0] c);
        case (c[8:7]) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 14; endcase
    endfunction

    function automatic int lim_of(logic [15:0] c);
        case (c[11:9])
            3'd0: return 15; 3'd1: return 1;  3'd2: return 4;  3'd3: return 6;
            3'd4: return 8;  3'd5: return 10; 3'd6: return 12; default: return 14;
        endcase
    endfunction

    function automatic logic [15:0] stat_exp();
        int n = q.size();
        if (n >= trig_of(m_ctl)) return 16'h0062;
        return (n != 0) ? 16'h0061 : 16'h0060;
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(bit cs, bit we, logic [1:0] a, logic [15:0] wd,
                        bit rv, logic [7:0] rb, string tag);
        bit pop, was_full, ovf;
        @(negedge clk);
        bus_cs = cs; bus_we = we; bus_addr = a; bus_wdata = wd;
        rx_valid = rv; rx_byte = rb;
        #1;
        chk("R5 ready", {15'h0, rx_ready}, {15'h0, (q.size() < lim_of(m_ctl))});
        if (cs && !we) begin
            case (a)
                2'd0: chk(tag != "" ? tag : (q.size() == 0 ? "R8 empty read" : "R2 data"),
                          bus_rdata, q.size() == 0 ? 16'h0 : {8'h0, q[0]});
                2'd1: chk(tag != "" ? tag : "R10 ctl", bus_rdata, m_ctl);
                2'd2: chk(tag != "" ? tag : (q.size() >= trig_of(m_ctl) ? "R3 status" : "R4 status"),
                          bus_rdata, stat_exp());
                default: chk(tag != "" ? tag : "R7 line", bus_rdata, m_line);
            endcase
        end
        was_full = (q.size() == 16);
        pop = cs && !we && a == 2'd0 && q.size() > 0;
        ovf = 1'b0;
        if (pop) void'(q.pop_front());
        if (rv) begin
            if (!was_full || pop) q.push_back(rb);
            else ovf = 1'b1;
        end
        if (cs && we && a == 2'd3)       m_line = wd | {15'h0, ovf};
        else if (cs && !we && a == 2'd3) m_line = {15'h0, ovf};
        else if (ovf)                    m_line[0] = 1'b1;
        if (cs && we && a == 2'd1) m_ctl = wd;
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 2'd0, 16'h0, 1'b0, 8'h0, "");
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1 reset values
        step(1, 0, 2'd2, 0, 0, 0, "R1 status reset");
        step(1, 0, 2'd1, 0, 0, 0, "R1 ctl reset");
        step(1, 0, 2'd3, 0, 0, 0, "R1 line reset");
        chk("R1 ready reset", {15'h0, rx_ready}, 16'h1);
        // R8 pop from empty
        step(1, 0, 2'd0, 0, 0, 0, "R8 empty pop");
        step(1, 0, 2'd2, 0, 0, 0, "R8 still empty");
        // R3 trigger 14, limit 15: fill to 16
        step(1, 1, 2'd1, 16'h0180, 0, 0, "");
        for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 1, 8'(8'h30 + i), "");
        step(1, 0, 2'd2, 0, 0, 0, "R3 full status");
        // R6 overflow, R7 coincident line read keeps overrun
        step(0, 0, 0, 0, 1, 8'hEE, "");
        step(1, 0, 2'd3, 0, 1, 8'hEF, "R6 overrun set");
        step(1, 0, 2'd3, 0, 0, 0, "R7 overrun held after coincident read");
        step(1, 0, 2'd3, 0, 0, 0, "R7 cleared");
        // R9 full push + pop
        step(1, 0, 2'd0, 0, 1, 8'hA5, "R9 pop while full");
        step(1, 0, 2'd2, 0, 0, 0, "R9 count kept");
        // R10 ignored writes, line load
        step(1, 1, 2'd2, 16'hFFFF, 0, 0, "");
        step(1, 1, 2'd0, 16'hFFFF, 0, 0, "");
        step(1, 0, 2'd2, 0, 0, 0, "R10 status unchanged");
        step(1, 1, 2'd3, 16'h00F0, 0, 0, "");
        step(1, 0, 2'd3, 0, 0, 0, "R10 line load");
        // R2 drain in order
        for (int i = 0; i < 16; i++) step(1, 0, 2'd0, 0, 0, 0, "R2 ordered drain");
        step(1, 0, 2'd2, 0, 0, 0, "R4 empty status");
        // random phases
        for (int ph = 0; ph < 20; ph++) begin
            int pp = (ph % 2 == 0) ? 85 : 20;
            for (int k = 0; k < 200; k++) begin
                int r = $urandom_range(0, 99);
                bit rv = ($urandom_range(0, 99) < pp);
                logic [7:0] rb = 8'($urandom);
                if (r < 30)      step(1, 0, 2'd0, 0, rv, rb, "");
                else if (r < 34) step(1, 1, 2'd1, 16'($urandom), rv, rb, "");
                else if (r < 40) step(1, 0, 2'd3, 0, rv, rb, "");
                else if (r < 55) step(1, 0, 2'd2, 0, rv, rb, "");
                else if (r < 58) step(1, 0, 2'd1, 0, rv, rb, "");
                else             step(0, 0, 2'd0, 0, rv, rb, "");
            end
        end
        idle();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule